// File: doc/BRIEF.md
# I2C Register Port with Bus-Programmable Device Address

This block is a two-wire slave control port for a register file. The bus master supplies the clock. The data line is open-drain: the port only ever pulls it low. A transaction starts with a device byte. Bits 7..1 of that byte are the 7-bit device address and bit 0 is the direction (1 = read, 0 = write). In a write, the byte after the device byte loads an 8-bit register pointer, and every later byte is stored at the pointer. In a read, the port shifts out the register at the pointer. The pointer advances by one after every data byte in either direction, so a burst touches consecutive registers.

The device address is not wired in; it is set over the bus. A strap input sampled during reset must be high or the port stays silent. A per-device hold input keeps the port completely deaf while it is high. Once hold is released, the port answers to the default address 0000000. The master uses that address to write the address-configuration register, which sits at pointer `CFG_PTR` (default 0xFF). That register holds bit 7 = enable and bits 6..0 = device address. After enable is written as 1, the port answers only to the programmed address.

Identical devices on one bus are brought up one at a time. Each device's hold is released in turn, and that device is given its own address before the next hold is dropped.

Top module: `regport_i2c_slave`

## Requirements
- R1: When `cs_strap` is low while `rst_n` is low, the port never drives the data line and never writes, whatever bus traffic follows.
- R2: While `hold_in` is high, the port ignores all bus traffic: it gives no acknowledge and no `reg_wr_en` pulse.
- R3: After reset and before enable is set, a device byte whose bits 7..1 equal 0000000 is acknowledged. Any other device address gets no acknowledge and no write.
- R4: Writing a byte with bit 7 = 1 to pointer `CFG_PTR` makes the port acknowledge only device address bits 6..0 of that byte. The default address 0000000 is then no longer answered.
- R5: In a write, the byte after the device byte loads the pointer. Each later byte gives one single-cycle `reg_wr_en` pulse, with `reg_wr_addr` = pointer and `reg_wr_data` = the byte, and the pointer then increments.
- R6: In a read, the port sends the register at the pointer MSB first, and the pointer increments after each byte sent. Data comes from `reg_rd_data` (addressed by `reg_rd_addr`), or from the configuration register when the pointer equals `CFG_PTR`.
- R7: After each byte it accepts (matching device byte, pointer byte, data byte), the port holds the data line low for the whole high phase of the 9th clock. It changes its drive only while the clock is low.
- R8: A master NACK (data line high on the 9th clock of a read byte) ends the read. The port releases the data line and does not drive it again until a new start.
- R9: A repeated start restarts byte framing with a new device byte. The pointer keeps its value across repeated starts and across stop conditions.
- R10: After a stop, clock pulses without a new start condition are ignored: no acknowledge and no write.
- R11: Writes to pointer `CFG_PTR` update the configuration register and never appear on `reg_wr_en`. Reading `CFG_PTR` returns {enable, address}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_strap | input | 1 | Mode strap, sampled while reset is low; high enables this port |
| hold_in | input | 1 | High keeps the port deaf to the bus |
| scl_in | input | 1 | Bus clock from the master |
| sda_in | input | 1 | Resolved level of the bus data line |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| reg_wr_en | output | 1 | One-cycle register write strobe |
| reg_wr_addr | output | 8 | Register index for the write |
| reg_wr_data | output | 8 | Byte to write |
| reg_rd_addr | output | 8 | Current pointer, used to index the register file for reads |
| reg_rd_data | input | 8 | Register contents at `reg_rd_addr`, combinational |

## Verification
The bench goes after the address hand-over. If the port kept answering 0000000 after enable was set, a second device could never be brought up. If the port answered before the strap or hold allowed it, the unconfigured devices would collide on the bus. It drives a repeated start between pointer setup and a read burst, then reads again after a stop. A port that reset the pointer on either event would return the register at index 0 instead of the next one. It also clocks one more bit after a NACK and clocks a byte after a stop with no start. A port that kept sending or mistook bus clocks for a transaction would pull the line low there.

// File: rtl/regport_pkg.sv
// Shared types and fixed protocol widths for the register port.
// Assumes a byte-oriented two-wire bus with 7-bit device addresses.
package regport_pkg;
    localparam int BYTE_W = 8;
    localparam int DEV_W  = 7;
    localparam int CNT_W  = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK
    } port_state_t;

    typedef enum logic [1:0] {
        BK_DEV,
        BK_PTR,
        BK_DATA
    } byte_kind_t;
endpackage

// File: rtl/regport_line_sync.sv
// Synchronises the bus clock, bus data and hold lines into clk, then flags
// clock edges and start/stop conditions one cycle after they are seen.
// Assumes each bus phase lasts several clk cycles.
module regport_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    input  logic hold_in,
    output logic scl_s,
    output logic sda_s,
    output logic hold_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int LINES = 3;
    localparam logic [LINES-1:0] IDLE_LVL = 3'b011;

    logic [LINES-1:0] chain [STAGES];
    logic             scl_p;
    logic             sda_p;

    // Shift the raw lines through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= IDLE_LVL;
        end else begin
            chain[0] <= {hold_in, sda_in, scl_in};
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign scl_s  = chain[STAGES-1][0];
    assign sda_s  = chain[STAGES-1][1];
    assign hold_s = chain[STAGES-1][2];

    // Keep the previous synchronised levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_det = scl_s & scl_p & ~sda_s & sda_p;
    assign stop_det  = scl_s & scl_p & sda_s & ~sda_p;
endmodule

// File: rtl/regport_addr_cfg.sv
// Holds the bus-programmable device address and its enable bit, and decides
// whether a received device address selects this port.
// Assumes writes arrive as a one-cycle strobe with the full config byte.
module regport_addr_cfg
    import regport_pkg::*;
#(
    parameter logic [DEV_W-1:0] DEFAULT_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [BYTE_W-1:0] cfg_wd,
    input  logic [DEV_W-1:0]  cand_addr,
    output logic              dev_match,
    output logic [BYTE_W-1:0] cfg_value
);
    logic             addr_en;
    logic [DEV_W-1:0] dev_addr;

    // Capture the configuration byte on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_en  <= 1'b0;
            dev_addr <= '0;
        end else if (cfg_we) begin
            addr_en  <= cfg_wd[BYTE_W-1];
            dev_addr <= cfg_wd[DEV_W-1:0];
        end
    end

    // Compare against the programmed address once enabled, else the default.
    always_comb begin
        if (addr_en) dev_match = (cand_addr == dev_addr);
        else         dev_match = (cand_addr == DEFAULT_ADDR);
    end

    assign cfg_value = {addr_en, dev_addr};
endmodule

// File: rtl/regport_i2c_slave.sv
// Two-wire slave register port: frames bytes, acknowledges, loads and
// advances the register pointer, writes and reads registers, and drives the
// open-drain data line. Assumes reg_rd_data follows reg_rd_addr combinationally.
module regport_i2c_slave
    import regport_pkg::*;
#(
    parameter int                SYNC_STAGES  = 2,
    parameter logic [DEV_W-1:0]  DEFAULT_ADDR = '0,
    parameter logic [BYTE_W-1:0] CFG_PTR      = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_strap,
    input  logic              hold_in,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_oe,
    output logic              reg_wr_en,
    output logic [BYTE_W-1:0] reg_wr_addr,
    output logic [BYTE_W-1:0] reg_wr_data,
    output logic [BYTE_W-1:0] reg_rd_addr,
    input  logic [BYTE_W-1:0] reg_rd_data
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] FULL     = CNT_W'(BYTE_W);

    logic scl_s, sda_s, hold_s;
    logic scl_rise, scl_fall, start_det, stop_det;

    logic              mode_q;
    port_state_t       state;
    byte_kind_t        kind;
    logic              rw_read;
    logic              master_ack;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] ptr;
    logic              cfg_we;
    logic [BYTE_W-1:0] cfg_wd;
    logic              dev_match;
    logic [BYTE_W-1:0] cfg_value;
    logic [BYTE_W-1:0] rd_byte;

    regport_line_sync #(
        .STAGES   (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl_in),
        .sda_in   (sda_in),
        .hold_in  (hold_in),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .hold_s   (hold_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    regport_addr_cfg #(
        .DEFAULT_ADDR(DEFAULT_ADDR)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_wd   (cfg_wd),
        .cand_addr(shreg[BYTE_W-1:1]),
        .dev_match(dev_match),
        .cfg_value(cfg_value)
    );

    // Select the byte to send: config register or external register file.
    always_comb begin
        if (ptr == CFG_PTR) rd_byte = cfg_value;
        else                rd_byte = reg_rd_data;
    end

    assign reg_rd_addr = ptr;

    // Main framing state machine, clocked by oversampled bus events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q      <= cs_strap;
            state       <= ST_IDLE;
            kind        <= BK_DEV;
            rw_read     <= 1'b0;
            master_ack  <= 1'b0;
            bit_cnt     <= '0;
            shreg       <= '0;
            ptr         <= '0;
            sda_oe      <= 1'b0;
            reg_wr_en   <= 1'b0;
            reg_wr_addr <= '0;
            reg_wr_data <= '0;
            cfg_we      <= 1'b0;
            cfg_wd      <= '0;
        end else begin
            reg_wr_en <= 1'b0;
            cfg_we    <= 1'b0;
            if (!mode_q || hold_s) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else if (start_det) begin
                state   <= ST_RX;
                kind    <= BK_DEV;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else if (stop_det) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_RX: begin
                        if (scl_rise && bit_cnt != FULL) begin
                            shreg   <= {shreg[BYTE_W-2:0], sda_s};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (scl_fall && bit_cnt == FULL) begin
                            case (kind)
                                BK_DEV: begin
                                    if (dev_match) begin
                                        rw_read <= shreg[0];
                                        sda_oe  <= 1'b1;
                                        state   <= ST_RX_ACK;
                                    end else begin
                                        state <= ST_IDLE;
                                    end
                                end
                                BK_PTR: begin
                                    ptr    <= shreg;
                                    sda_oe <= 1'b1;
                                    state  <= ST_RX_ACK;
                                end
                                default: begin
                                    if (ptr == CFG_PTR) begin
                                        cfg_we <= 1'b1;
                                        cfg_wd <= shreg;
                                    end else begin
                                        reg_wr_en   <= 1'b1;
                                        reg_wr_addr <= ptr;
                                        reg_wr_data <= shreg;
                                    end
                                    ptr    <= ptr + 1'b1;
                                    sda_oe <= 1'b1;
                                    state  <= ST_RX_ACK;
                                end
                            endcase
                        end
                    end
                    ST_RX_ACK: begin
                        if (scl_fall) begin
                            bit_cnt <= '0;
                            if (kind == BK_DEV && rw_read) begin
                                shreg  <= rd_byte;
                                sda_oe <= ~rd_byte[BYTE_W-1];
                                kind   <= BK_DATA;
                                state  <= ST_TX;
                            end else begin
                                sda_oe <= 1'b0;
                                kind   <= (kind == BK_DEV) ? BK_PTR : BK_DATA;
                                state  <= ST_RX;
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            if (bit_cnt == LAST_BIT) begin
                                sda_oe <= 1'b0;
                                ptr    <= ptr + 1'b1;
                                state  <= ST_TX_ACK;
                            end else begin
                                shreg   <= {shreg[BYTE_W-2:0], 1'b0};
                                sda_oe  <= ~shreg[BYTE_W-2];
                                bit_cnt <= bit_cnt + 1'b1;
                            end
                        end
                    end
                    ST_TX_ACK: begin
                        if (scl_rise) begin
                            master_ack <= ~sda_s;
                        end else if (scl_fall) begin
                            if (master_ack) begin
                                shreg   <= rd_byte;
                                sda_oe  <= ~rd_byte[BYTE_W-1];
                                bit_cnt <= '0;
                                state   <= ST_TX;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    default: begin
                        sda_oe <= 1'b0;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/regport_i2c_slave_chk.sv
// Property checker for the register port, bound into every instance.
// Assumes it sees the synchronised bus clock and hold levels of the port.
module regport_i2c_slave_chk #(
    parameter logic [7:0] CFG_PTR = 8'hFF
) (
    input logic       clk,
    input logic       rst_n,
    input logic       mode_q,
    input logic       hold_s,
    input logic       scl_s,
    input logic       sda_oe,
    input logic       reg_wr_en,
    input logic [7:0] reg_wr_addr
);
    // R1
    strap_low_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_q |-> (!sda_oe && !reg_wr_en));

    // R2
    hold_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_s |=> !sda_oe);

    // R2
    hold_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_s |=> !reg_wr_en);

    // R5
    write_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> !reg_wr_en);

    // R7
    drive_on_low_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !$past(scl_s));

    // R11
    cfg_not_forwarded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |-> (reg_wr_addr != CFG_PTR));
endmodule

bind regport_i2c_slave regport_i2c_slave_chk #(
    .CFG_PTR(CFG_PTR)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_q     (mode_q),
    .hold_s     (hold_s),
    .scl_s      (scl_s),
    .sda_oe     (sda_oe),
    .reg_wr_en  (reg_wr_en),
    .reg_wr_addr(reg_wr_addr)
);

// File: tb/regport_i2c_slave_bench.sv
// Scoreboard bench: bus tasks push expected register writes into a queue,
// a monitor pops them on each write strobe; acks and read bytes are compared
// inline against a bench-side register model.
module regport_i2c_slave_bench;
    localparam int Q = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_strap = 1'b0;
    logic       hold_in = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       sda_bus;
    logic       sda_oe;
    logic       reg_wr_en;
    logic [7:0] reg_wr_addr, reg_wr_data, reg_rd_addr, reg_rd_data;

    logic [7:0] mem [256];
    logic [7:0] exp_mem [256];
    logic [15:0] exp_wr_q [$];
    int n_cmp = 0, n_bad = 0, wr_seen = 0;
    bit done = 0;

    always #4 clk = ~clk;

    assign sda_bus = m_sda & ~sda_oe;
    assign reg_rd_data = mem[reg_rd_addr];

    regport_i2c_slave u_regport_i2c_slave (
        .clk(clk), .rst_n(rst_n), .cs_strap(cs_strap), .hold_in(hold_in),
        .scl_in(m_scl), .sda_in(sda_bus), .sda_oe(sda_oe),
        .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
        .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data)
    );

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i]     = 8'(i * 7 + 3);
            exp_mem[i] = 8'(i * 7 + 3);
        end
    end

    always @(posedge clk) if (reg_wr_en) mem[reg_wr_addr] <= reg_wr_data;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor: compare each write strobe with the next expected write (R5).
    always @(negedge clk) begin
        if (reg_wr_en) begin
            wr_seen++;
            if (exp_wr_q.size() == 0) check("R5 unexpected write", {reg_wr_addr, reg_wr_data}, 32'hFFFF_FFFF);
            else check("R5 write", {reg_wr_addr, reg_wr_data}, exp_wr_q.pop_front());
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_tx(input logic b);
        m_sda = b; wait_clk(Q); m_scl = 1'b1; wait_clk(2 * Q); m_scl = 1'b0;
    endtask

    task automatic bit_rx(output logic b);
        m_sda = 1'b1; wait_clk(Q); m_scl = 1'b1; wait_clk(Q); b = sda_bus; wait_clk(Q); m_scl = 1'b0;
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wait_clk(Q); m_scl = 1'b1; wait_clk(Q); m_sda = 1'b0; wait_clk(Q); m_scl = 1'b0;
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wait_clk(Q); m_scl = 1'b1; wait_clk(Q); m_sda = 1'b1; wait_clk(Q);
    endtask

    // Send one byte and compare the acknowledge (1 = line pulled low).
    task automatic send_byte(input logic [7:0] v, input logic exp_ack, input string req);
        logic b;
        for (int i = 7; i >= 0; i--) bit_tx(v[i]);
        bit_rx(b);
        check(req, {31'd0, ~b}, {31'd0, exp_ack});
    endtask

    // Write data byte with the expected register write pushed first.
    task automatic send_data(input logic [7:0] ptr, input logic [7:0] v, input string req);
        exp_wr_q.push_back({ptr, v});
        exp_mem[ptr] = v;
        send_byte(v, 1'b1, req);
    endtask

    task automatic read_byte(input logic [7:0] exp, input logic give_ack, input string req);
        logic [7:0] v;
        logic b;
        for (int i = 7; i >= 0; i--) begin
            bit_rx(b);
            v[i] = b;
        end
        bit_tx(~give_ack);
        check(req, {24'd0, v}, {24'd0, exp});
    endtask

    task automatic do_reset(input logic strap);
        rst_n = 1'b0; cs_strap = strap; wait_clk(4); rst_n = 1'b1; wait_clk(2);
    endtask

    initial begin
        logic b;
        int wr_before;
        // R1: strap low leaves the port silent.
        do_reset(1'b0);
        bus_start();
        send_byte(8'h00, 1'b0, "R1 no ack with strap low");
        bus_stop();
        do_reset(1'b1);
        check("R1 reset sda_oe", {31'd0, sda_oe}, 0);
        check("R5 reset wr_en", {31'd0, reg_wr_en}, 0);

        // R2: hold keeps the port deaf.
        hold_in = 1'b1; wait_clk(5);
        wr_before = wr_seen;
        bus_start();
        send_byte(8'h00, 1'b0, "R2 no ack device byte under hold");
        send_byte(8'h20, 1'b0, "R2 no ack pointer under hold");
        send_byte(8'h55, 1'b0, "R2 no ack data under hold");
        bus_stop();
        check("R2 no write under hold", wr_seen, wr_before);
        hold_in = 1'b0; wait_clk(5);

        // R3: default address only.
        bus_start();
        send_byte(8'h46, 1'b0, "R3 other address ignored");
        bus_stop();
        // R5/R7: write burst at default address.
        bus_start();
        send_byte(8'h00, 1'b1, "R3 default address acked");
        send_byte(8'h10, 1'b1, "R7 pointer byte acked");
        send_data(8'h10, 8'hA1, "R7 data byte acked");
        send_data(8'h11, 8'hB2, "R7 second data byte acked");
        bus_stop();

        // R9/R6: pointer set, repeated start, read burst.
        bus_start();
        send_byte(8'h00, 1'b1, "R9 write device byte");
        send_byte(8'h10, 1'b1, "R9 pointer load");
        bus_start();
        send_byte(8'h01, 1'b1, "R9 read device byte after repeated start");
        read_byte(exp_mem[8'h10], 1'b1, "R6 read first byte");
        read_byte(exp_mem[8'h11], 1'b1, "R6 read second byte");
        read_byte(exp_mem[8'h12], 1'b0, "R6 read third byte with NACK");
        // R8: line stays released after NACK.
        bit_rx(b);
        check("R8 released after NACK", {31'd0, b}, 1);
        check("R8 no drive after NACK", {31'd0, sda_oe}, 0);
        bus_stop();

        // R9: pointer kept across stop.
        bus_start();
        send_byte(8'h01, 1'b1, "R9 read after stop");
        read_byte(exp_mem[8'h13], 1'b0, "R9 pointer kept across stop");
        bus_stop();

        // R10: clocks without start after a stop.
        wr_before = wr_seen;
        m_scl = 1'b0; wait_clk(Q);
        send_byte(8'h00, 1'b0, "R10 no ack without start");
        send_byte(8'h33, 1'b0, "R10 no ack second byte without start");
        bus_stop();
        check("R10 no write without start", wr_seen, wr_before);

        // R4/R11: program address 0x2A with enable.
        bus_start();
        send_byte(8'h00, 1'b1, "R4 default address before enable");
        send_byte(8'hFF, 1'b1, "R11 config pointer");
        send_byte(8'hAA, 1'b1, "R11 config byte acked");
        bus_stop();
        check("R11 config write not forwarded", wr_seen, wr_before);
        bus_start();
        send_byte(8'h00, 1'b0, "R4 default address dropped");
        bus_stop();
        bus_start();
        send_byte(8'h54, 1'b1, "R4 programmed address acked");
        send_byte(8'hFF, 1'b1, "R11 config pointer reload");
        bus_start();
        send_byte(8'h55, 1'b1, "R4 programmed address read");
        read_byte(8'hAA, 1'b1, "R11 config readback");
        read_byte(exp_mem[8'h00], 1'b0, "R6 pointer wraps to zero");
        bus_stop();

        wait_clk(10);
        check("R5 all expected writes seen", exp_wr_q.size(), 0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule